// File: doc/BRIEF.md
# Color Table Host Register Interface

This block sits between a host processor and a 24-bit color lookup table. A host access is an active-low chip-enable strobe together with a 3-bit register select, a read/write bit and an 8-bit data byte. At the clock edge where the block first sees the strobe low, it captures the access and carries it out. It holds a 13-bit table address that advances by itself, and a three-phase byte sequencer that collects a red, a green and a blue byte. Once the third byte arrives it pushes the complete color, tagged with its address, into an external write queue. The queue's level flags come back to the block and appear in a status byte. The block also passes some command bits on to the timing pipeline.

Reading the table back is bracketed by two commands. The first opens a read window and fetches the word at the current address over a request/response port. The second closes the window. Inside the window, palette reads return the fetched word one byte at a time, then step the address and fetch the next word. A buffer keeps the red and green bytes of an unfinished write so that the host can recover them. The data bus is split into an input byte, an output byte and an output enable, so the block can drive a shared pad. All host inputs are synchronous to `clk`.

Top module: `pal_host_if`

## Requirements
- R1: An access is taken at the first rising clock edge where `host_ce_n` is low after being high. `host_rw`=1 means read and 0 means write. `host_rdata_oe` is high only while `host_ce_n` stays low after a captured read, and `host_rdata` holds the read byte during that time.
- R2: Select 0 is the low address byte and select 1 carries address bits 12:8. A write to select 1 uses only data bits 4:0. A read of select 1 returns zeros in bits 7:5.
- R3: A write to either address select sets the byte phase back to red (phase 0).
- R4: The byte phase takes the values 0 (red), 1 (green) and 2 (blue), in that order, and never 3. It is visible as status bits 1:0.
- R5: Palette writes (select 2) work as follows. A write in phase 0 stores the red byte and a write in phase 1 stores the green byte. A write in phase 2 pulses `fifo_push`, with `fifo_addr` set to the current address and `fifo_rgb` = {blue, green, red} (red in bits 7:0, green in 15:8, blue in 23:16). That write also returns the phase to 0 and increments the address, wrapping from 0x1FFF to 0.
- R6: Reads of select 5 return the stored red byte in phase 0 and then the stored green byte in phase 1, each advancing the phase. A read in phase 2 returns 0x00 and changes nothing.
- R7: The status byte (select 4) is {3'b000, full, level, empty, phase[1:0]}. All flags are active high. The level bit and the `flag_level` output are `fifo_almost` when command bit 4 is 1 and `fifo_half` when it is 0.
- R8: The command byte (select 3) can be written and read back in full. Bits 3:0 drive `pipe_force`.
- R9: The revision byte (select 6) reads {board_rev, 1'b0, REV_ID}. With the default REV_ID of 5, this is 0xA5 when `board_rev`=0xA.
- R10: Reset (`rst_n` low) sets the address to 0, the phase to 0, both buffer bytes to 0 and the command byte to 0x03. It closes the read window and keeps `host_rdata_oe` low.
- R11: Writing select 7 opens the read window, sets the phase to 0 and requests the word at the current address on `mem_rd_req`/`mem_rd_addr`. Reading select 7 closes the window and returns 0x00. `rd_mode_o` shows whether the window is open.
- R12: Inside the window, palette reads return red, green and blue of the fetched word in phase order. After the blue byte the address increments and the next word is requested. An address write inside the window also requests the word at the new address.
- R13: A palette read outside the read window returns 0x00 and leaves the address and the phase unchanged.
- R14: Writes to selects 4, 5 and 6 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce_n | input | 1 | Host access strobe, active low |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_sel | input | 3 | Register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rdata_oe | output | 1 | Output enable for the host data pads |
| board_rev | input | 4 | Board revision straps |
| fifo_empty | input | 1 | Write queue empty |
| fifo_half | input | 1 | Write queue at least half full |
| fifo_almost | input | 1 | Write queue almost full |
| fifo_full | input | 1 | Write queue full |
| fifo_push | output | 1 | Push one color entry |
| fifo_addr | output | 13 | Table address of the pushed entry |
| fifo_rgb | output | 24 | Pushed color {blue, green, red} |
| flag_level | output | 1 | Selected half/almost-full flag |
| pipe_force | output | 4 | Command bits 3:0 to the timing pipeline |
| mem_rd_req | output | 1 | Table read request pulse |
| mem_rd_addr | output | 13 | Table read address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 24 | Table read word |
| rd_mode_o | output | 1 | Read window open |

## Verification
The hardest state to reach is one where the sequencer phase, the read window and a pending table fetch all interact. An example is an address write inside an open window, which must set the phase back and fetch a new word before the next red read. The stimulus opens the window, reads a whole triple so that the address advances by itself, then rewrites the low address in the middle of the window. It checks every returned byte against a table function computed in the bench. A partial write triple is left unfinished on purpose, and the color-buffer recovery path is then driven through its invalid third read.

// File: rtl/pal_host_pkg.sv
package pal_host_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_PAL     = 3'd2,
    SEL_CMD     = 3'd3,
    SEL_STAT    = 3'd4,
    SEL_CBUF    = 3'd5,
    SEL_REV     = 3'd6,
    SEL_RDCTL   = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e phase_step(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [7:0] status_pack(phase_e p, logic empty,
                                             logic level, logic full);
    return {3'b000, full, level, empty, p};
  endfunction

  function automatic logic pick_level(logic mode, logic half, logic almost);
    return mode ? almost : half;
  endfunction

endpackage

// File: rtl/pal_host_capture.sv
module pal_host_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rw,
  output logic acc_go,
  output logic drive_win
);
  logic ce_q;
  logic rw_q;

  assign acc_go = ce_q & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      rw_q <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (acc_go) rw_q <= rw;
    end
  end

  assign drive_win = rst_n & ~ce_n & ~ce_q & rw_q;
endmodule

// File: rtl/pal_host_seq.sv
module pal_host_seq
  import pal_host_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8,
  localparam int HI_W  = ADDR_W - BYTE_W,
  localparam int RGB_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_go,
  input  logic              acc_rw,
  input  sel_e              acc_sel,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] addr,
  output phase_e            phase,
  output logic [BYTE_W-1:0] cbuf_red,
  output logic [BYTE_W-1:0] cbuf_grn,
  output logic [BYTE_W-1:0] cmd,
  output logic              rd_mode,
  output logic              push_ev,
  output logic [RGB_W-1:0]  push_rgb,
  output logic              fetch_ev
);
  logic wr_go, rd_go;
  logic addr_wr, pal_wr, pal_rd, cbuf_rd_ok, init_wr, term_rd, cmd_wr;
  logic addr_step;

  assign wr_go = acc_go & ~acc_rw;
  assign rd_go = acc_go &  acc_rw;

  assign addr_wr    = wr_go & ((acc_sel == SEL_ADDR_LO) | (acc_sel == SEL_ADDR_HI));
  assign pal_wr     = wr_go & (acc_sel == SEL_PAL);
  assign cmd_wr     = wr_go & (acc_sel == SEL_CMD);
  assign init_wr    = wr_go & (acc_sel == SEL_RDCTL);
  assign pal_rd     = rd_go & (acc_sel == SEL_PAL) & rd_mode;
  assign cbuf_rd_ok = rd_go & (acc_sel == SEL_CBUF) & (phase != PH_BLU);
  assign term_rd    = rd_go & (acc_sel == SEL_RDCTL);

  assign push_ev   = pal_wr & (phase == PH_BLU);
  assign push_rgb  = {acc_wdata, cbuf_grn, cbuf_red};
  assign addr_step = push_ev | (pal_rd & (phase == PH_BLU));
  assign fetch_ev  = init_wr | (addr_wr & rd_mode) | (pal_rd & (phase == PH_BLU));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (wr_go && acc_sel == SEL_ADDR_LO) begin
      addr[BYTE_W-1:0] <= acc_wdata;
    end else if (wr_go && acc_sel == SEL_ADDR_HI) begin
      addr[ADDR_W-1:BYTE_W] <= acc_wdata[HI_W-1:0];
    end else if (addr_step) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RED;
    end else if (addr_wr || init_wr) begin
      phase <= PH_RED;
    end else if (pal_wr || pal_rd || cbuf_rd_ok) begin
      phase <= phase_step(phase);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbuf_red <= '0;
      cbuf_grn <= '0;
    end else if (pal_wr && phase == PH_RED) begin
      cbuf_red <= acc_wdata;
    end else if (pal_wr && phase == PH_GRN) begin
      cbuf_grn <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= BYTE_W'(3);
      rd_mode <= 1'b0;
    end else begin
      if (cmd_wr)  cmd <= acc_wdata;
      if (init_wr) rd_mode <= 1'b1;
      else if (term_rd) rd_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_host_fetch.sv
module pal_host_fetch #(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_ev,
  output logic             mem_rd_req,
  input  logic             mem_rd_valid,
  input  logic [RGB_W-1:0] mem_rd_data,
  output logic [RGB_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_req <= 1'b0;
      word       <= '0;
    end else begin
      mem_rd_req <= fetch_ev;
      if (mem_rd_valid) word <= mem_rd_data;
    end
  end
endmodule

// File: rtl/pal_host_rdmux.sv
module pal_host_rdmux
  import pal_host_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8,
  parameter int BRD_W  = 4,
  parameter logic [2:0] REV_ID = 3'd5,
  localparam int HI_W  = ADDR_W - BYTE_W,
  localparam int RGB_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  sel_e              acc_sel,
  input  logic [ADDR_W-1:0] addr,
  input  phase_e            phase,
  input  logic [BYTE_W-1:0] cbuf_red,
  input  logic [BYTE_W-1:0] cbuf_grn,
  input  logic [BYTE_W-1:0] cmd,
  input  logic              rd_mode,
  input  logic [RGB_W-1:0]  word,
  input  logic [BYTE_W-1:0] status,
  input  logic [BRD_W-1:0]  board_rev,
  output logic [BYTE_W-1:0] rd_q
);
  logic [BYTE_W-1:0] rd_next;
  logic [BYTE_W-1:0] pal_byte;

  always_comb begin
    case (phase)
      PH_RED:  pal_byte = word[BYTE_W-1:0];
      PH_GRN:  pal_byte = word[2*BYTE_W-1:BYTE_W];
      default: pal_byte = word[RGB_W-1:2*BYTE_W];
    endcase
  end

  always_comb begin
    rd_next = '0;
    case (acc_sel)
      SEL_ADDR_LO: rd_next = addr[BYTE_W-1:0];
      SEL_ADDR_HI: rd_next = BYTE_W'(addr[ADDR_W-1:ADDR_W-HI_W]);
      SEL_PAL:     rd_next = rd_mode ? pal_byte : '0;
      SEL_CMD:     rd_next = cmd;
      SEL_STAT:    rd_next = status;
      SEL_CBUF:    rd_next = (phase == PH_RED) ? cbuf_red :
                             (phase == PH_GRN) ? cbuf_grn : '0;
      SEL_REV:     rd_next = BYTE_W'({board_rev, 1'b0, REV_ID});
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_go) rd_q <= rd_next;
  end
endmodule

// File: rtl/pal_host_if.sv
module pal_host_if
  import pal_host_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8,
  parameter int BRD_W  = 4,
  parameter logic [2:0] REV_ID = 3'd5,
  localparam int RGB_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ce_n,
  input  logic              host_rw,
  input  logic [2:0]        host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic [BRD_W-1:0]  board_rev,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  input  logic              fifo_almost,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic [RGB_W-1:0]  fifo_rgb,
  output logic              flag_level,
  output logic [3:0]        pipe_force,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [RGB_W-1:0]  mem_rd_data,
  output logic              rd_mode_o
);
  logic              acc_go;
  logic              drive_win;
  sel_e              acc_sel;
  logic [ADDR_W-1:0] addr;
  phase_e            phase;
  logic [BYTE_W-1:0] cbuf_red, cbuf_grn, cmd, status, rd_q;
  logic              rd_mode, push_ev, fetch_ev;
  logic [RGB_W-1:0]  push_rgb, word;
  logic [1:0]        phase_bits;

  assign acc_sel    = sel_e'(host_sel);
  assign phase_bits = phase;

  pal_host_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(host_ce_n), .rw(host_rw),
    .acc_go(acc_go), .drive_win(drive_win)
  );

  pal_host_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_rw(host_rw),
    .acc_sel(acc_sel), .acc_wdata(host_wdata), .addr(addr), .phase(phase),
    .cbuf_red(cbuf_red), .cbuf_grn(cbuf_grn), .cmd(cmd), .rd_mode(rd_mode),
    .push_ev(push_ev), .push_rgb(push_rgb), .fetch_ev(fetch_ev)
  );

  pal_host_fetch #(.RGB_W(RGB_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_ev(fetch_ev), .mem_rd_req(mem_rd_req),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .word(word)
  );

  assign flag_level = pick_level(cmd[4], fifo_half, fifo_almost);
  assign status     = status_pack(phase, fifo_empty, flag_level, fifo_full);

  pal_host_rdmux #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BRD_W(BRD_W),
                   .REV_ID(REV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(acc_go & host_rw), .acc_sel(acc_sel),
    .addr(addr), .phase(phase), .cbuf_red(cbuf_red), .cbuf_grn(cbuf_grn),
    .cmd(cmd), .rd_mode(rd_mode), .word(word), .status(status),
    .board_rev(board_rev), .rd_q(rd_q)
  );

  assign host_rdata    = rd_q;
  assign host_rdata_oe = drive_win;
  assign fifo_push     = push_ev;
  assign fifo_addr     = addr;
  assign fifo_rgb      = push_rgb;
  assign pipe_force    = cmd[3:0];
  assign mem_rd_addr   = addr;
  assign rd_mode_o     = rd_mode;
endmodule

// File: rtl/pal_host_chk.sv
module pal_host_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_go,
  input logic              acc_rw,
  input logic [2:0]        acc_sel,
  input logic [1:0]        phase,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        cmd,
  input logic              fifo_push,
  input logic              mem_rd_req,
  input logic              rd_mode,
  input logic              oe,
  input logic              ce_n
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R4

  AST_PUSH_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> (phase == 2'd0) && (addr == ADDR_W'($past(addr) + 1'b1))); // R5

  AST_ADDR_WR_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_rw && (acc_sel == 3'd0 || acc_sel == 3'd1)) |=> phase == 2'd0); // R3

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_rw && (acc_sel == 3'd4 || acc_sel == 3'd5 || acc_sel == 3'd6))
    |=> ($stable(addr) && $stable(phase) && $stable(cmd))); // R14

  AST_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> rd_mode); // R11

  AST_OE_ONLY_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ce_n); // R1

  always_comb begin
    if (!rst_n) AST_RESET_TRISTATE: assert (!oe); // R10
  end
endmodule

bind pal_host_if pal_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_rw(host_rw),
  .acc_sel(host_sel), .phase(phase_bits), .addr(addr), .cmd(cmd),
  .fifo_push(fifo_push), .mem_rd_req(mem_rd_req), .rd_mode(rd_mode),
  .oe(host_rdata_oe), .ce_n(host_ce_n)
);

// File: tb/tb_pal_host_if.sv
module tb_pal_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ce_n = 1'b1, host_rw = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_rdata_oe;
  logic [3:0]  board_rev = 4'hA;
  logic        fifo_empty = 1'b1, fifo_half = 1'b0, fifo_almost = 1'b0, fifo_full = 1'b0;
  logic        fifo_push, flag_level, mem_rd_req, rd_mode_o;
  logic [12:0] fifo_addr, mem_rd_addr;
  logic [23:0] fifo_rgb;
  logic [3:0]  pipe_force;
  logic        mem_rd_valid = 1'b0;
  logic [23:0] mem_rd_data = 24'h0;

  int checks = 0, failures = 0;
  logic        push_seen;
  logic [12:0] push_addr;
  logic [23:0] push_rgb;
  logic        oe_seen;
  logic [12:0] last_req;

  pal_host_if dut (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .host_rw(host_rw),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .board_rev(board_rev),
    .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_almost(fifo_almost),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_addr(fifo_addr),
    .fifo_rgb(fifo_rgb), .flag_level(flag_level), .pipe_force(pipe_force),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .rd_mode_o(rd_mode_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [23:0] table_word(logic [12:0] a);
    return {~a[7:0], a[12:5], a[7:0] ^ 8'h3C};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (mem_rd_req) begin
        last_req = mem_rd_addr;
        @(negedge clk);
        @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = table_word(last_req);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic rw, input logic [2:0] sel, input logic [7:0] wd,
                     output logic [7:0] rd);
    @(negedge clk);
    host_rw = rw; host_sel = sel; host_wdata = wd;
    @(negedge clk);
    host_ce_n = 1'b0;
    #1;
    push_seen = fifo_push; push_addr = fifo_addr; push_rgb = fifo_rgb;
    @(negedge clk);
    @(negedge clk);
    rd = host_rdata; oe_seen = host_rdata_oe;
    host_ce_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
    logic [7:0] d;
    acc(1'b0, sel, wd, d);
  endtask

  task automatic rdx(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    acc(1'b1, sel, 8'h00, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(host_rdata_oe == 1'b0, "R10 oe low in reset", host_rdata_oe, 0);
    chk(pipe_force == 4'h3, "R10 R8 command reset bits", pipe_force, 4'h3);
    rst_n = 1'b1;
    rdx(3'd3, 8'h03, "R10 command reads 03");
    rdx(3'd0, 8'h00, "R10 address low zero");
    rdx(3'd4, 8'h04, "R10 R7 status after reset");
    chk(rd_mode_o == 1'b0, "R10 window closed", rd_mode_o, 0);
  endtask

  task automatic t_bus;
    logic [7:0] d;
    acc(1'b0, 3'd3, 8'h03, d);
    chk(oe_seen == 1'b0, "R1 no drive on write", oe_seen, 0);
    acc(1'b1, 3'd3, 8'h00, d);
    chk(oe_seen == 1'b1, "R1 drive on read", oe_seen, 1);
    chk(host_rdata_oe == 1'b0, "R1 release after strobe", host_rdata_oe, 0);
  endtask

  task automatic t_addr;
    wr(3'd0, 8'hA7);
    wr(3'd1, 8'hFF);
    rdx(3'd1, 8'h1F, "R2 address high masked");
    rdx(3'd0, 8'hA7, "R2 address low");
  endtask

  task automatic t_pal_write;
    wr(3'd0, 8'h23); wr(3'd1, 8'h01);
    wr(3'd2, 8'h11);
    rdx(3'd4, 8'h05, "R4 phase green in status");
    wr(3'd2, 8'h22);
    rdx(3'd4, 8'h06, "R4 phase blue in status");
    chk(push_seen == 1'b0, "R5 no push before blue", push_seen, 0);
    wr(3'd2, 8'h33);
    chk(push_seen == 1'b1, "R5 push on blue", push_seen, 1);
    chk(push_addr == 13'h0123, "R5 push address", push_addr, 13'h0123);
    chk(push_rgb == 24'h332211, "R5 push color", push_rgb, 24'h332211);
    rdx(3'd0, 8'h24, "R5 address incremented");
    rdx(3'd4, 8'h04, "R5 phase back to red");
  endtask

  task automatic t_wrap;
    wr(3'd0, 8'hFF); wr(3'd1, 8'h1F);
    wr(3'd2, 8'h01); wr(3'd2, 8'h02); wr(3'd2, 8'h03);
    chk(push_addr == 13'h1FFF, "R5 push at top address", push_addr, 13'h1FFF);
    rdx(3'd0, 8'h00, "R5 wrap low");
    rdx(3'd1, 8'h00, "R5 wrap high");
  endtask

  task automatic t_cbuf;
    wr(3'd0, 8'h50);
    wr(3'd2, 8'hAA); wr(3'd2, 8'hBB);
    rdx(3'd4, 8'h06, "R4 partial triple phase");
    wr(3'd0, 8'h50);
    rdx(3'd4, 8'h04, "R3 address write clears phase");
    rdx(3'd5, 8'hAA, "R6 recover red");
    rdx(3'd5, 8'hBB, "R6 recover green");
    rdx(3'd5, 8'h00, "R6 third read invalid");
    rdx(3'd4, 8'h06, "R6 third read leaves phase");
    wr(3'd1, 8'h00);
    rdx(3'd4, 8'h04, "R3 high write clears phase");
  endtask

  task automatic t_cmd;
    wr(3'd3, 8'h1C);
    rdx(3'd3, 8'h1C, "R8 command readback");
    chk(pipe_force == 4'hC, "R8 force outputs", pipe_force, 4'hC);
    fifo_half = 1'b1; fifo_almost = 1'b0; fifo_empty = 1'b0; fifo_full = 1'b1;
    @(negedge clk);
    chk(flag_level == 1'b0, "R7 almost mode flag", flag_level, 0);
    rdx(3'd4, 8'h10, "R7 status almost mode");
    wr(3'd3, 8'h00);
    chk(flag_level == 1'b1, "R7 half mode flag", flag_level, 1);
    rdx(3'd4, 8'h18, "R7 status half mode");
    fifo_half = 1'b0; fifo_full = 1'b0; fifo_empty = 1'b1;
  endtask

  task automatic t_ignored;
    rdx(3'd6, 8'hA5, "R9 revision byte");
    board_rev = 4'h3;
    rdx(3'd6, 8'h35, "R9 revision follows straps");
    wr(3'd0, 8'h40);
    wr(3'd6, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'h77);
    rdx(3'd4, 8'h04, "R14 status unchanged");
    rdx(3'd0, 8'h40, "R14 address unchanged");
    rdx(3'd3, 8'h00, "R14 command unchanged");
    rdx(3'd5, 8'hAA, "R14 color buffer unchanged");
  endtask

  task automatic t_rd_outside;
    wr(3'd0, 8'h60);
    rdx(3'd2, 8'h00, "R13 read outside window");
    rdx(3'd4, 8'h04, "R13 phase unchanged");
    rdx(3'd0, 8'h60, "R13 address unchanged");
  endtask

  task automatic t_pal_read;
    logic [23:0] w;
    wr(3'd0, 8'hBC); wr(3'd1, 8'h0A);
    wr(3'd7, 8'h00);
    chk(rd_mode_o == 1'b1, "R11 window open", rd_mode_o, 1);
    chk(last_req == 13'h0ABC, "R11 fetch address", last_req, 13'h0ABC);
    w = table_word(13'h0ABC);
    rdx(3'd2, w[7:0],   "R12 red byte");
    rdx(3'd2, w[15:8],  "R12 green byte");
    rdx(3'd2, w[23:16], "R12 blue byte");
    rdx(3'd0, 8'hBD, "R12 address stepped");
    w = table_word(13'h0ABD);
    rdx(3'd2, w[7:0], "R12 next word red");
    wr(3'd0, 8'h10);
    w = table_word(13'h0A10);
    chk(last_req == 13'h0A10, "R12 refetch on address write", last_req, 13'h0A10);
    rdx(3'd2, w[7:0], "R12 refetched red");
    rdx(3'd7, 8'h00, "R11 terminate returns zero");
    chk(rd_mode_o == 1'b0, "R11 window closed", rd_mode_o, 0);
  endtask

  task automatic t_reset_again;
    wr(3'd3, 8'hF0);
    wr(3'd0, 8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(host_rdata_oe == 1'b0, "R10 oe low in second reset", host_rdata_oe, 0);
    rst_n = 1'b1;
    rdx(3'd3, 8'h03, "R10 command restored");
    rdx(3'd0, 8'h00, "R10 address cleared");
    rdx(3'd5, 8'h00, "R10 color buffer cleared");
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bus();
    t_addr();
    t_pal_write();
    t_wrap();
    t_cbuf();
    t_cmd();
    t_ignored();
    t_rd_outside();
    t_pal_read();
    t_reset_again();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule